// File: doc/BRIEF.md
# Twelve-Hour Timekeeping Chain

This block keeps the time of day in a twelve-hour clock. The system clock drives every counter. A one-cycle `tick` enable, asserted once per second, is the only thing that moves the time forward. The block holds three counters in a cascade. The seconds counter and the minutes counter each run 00 to 59 and are built from a units BCD decade and a tens BCD decade. The hours counter runs 1 to 12 and is built from a units decade and a one-bit tens flag.

A counter moves on a tick only when every counter below it shows its last value. The seconds counter moves on every tick. The minutes counter moves when the seconds read 59. The hours counter moves when both the seconds and the minutes read 59. The time is read directly as BCD digits. The hours tens digit is a single bit.

Top module: `hms_timekeeper`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the outputs read 12:00:00. That is `hr_tens`=1, `hr_ones`=2, and every minute and second digit is 0.
- R2: A cycle with `tick` low changes no output digit.
- R3: On a tick, `sec_ones` goes up by one. When `sec_ones` is 9, it goes to 0 and `sec_tens` goes up by one.
- R4: On a tick with the seconds at 59, the seconds go to 00 and the minutes advance. On any other tick, the minutes do not change.
- R5: The minutes step through 00 to 59 and then back to 00. They change only on a tick with the seconds at 59.
- R6: On a tick that carries into the hours while they read 09, the hours become 10. That is `hr_tens`=1 and `hr_ones`=0.
- R7: On a tick that carries into the hours while they read 12, the hours become 01. That is `hr_tens`=0 and `hr_ones`=1.
- R8: Every digit stays legal BCD. The seconds and minutes tens digits are at most 5 and the units digits at most 9. The hours never read 00 or 13 to 19.
- R9: The hours change once every 3,600 ticks. After 43,200 ticks from reset, the time is back at 12:00:00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every counter |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second advance enable |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD, 0..5 |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD, 0..5 |
| hr_ones | output | 4 | Hours units digit, BCD |
| hr_tens | output | 1 | Hours tens digit, 0 or 1 |

## Verification
The hardest events to reach from the ports are the two hour carries: 09 to 10, and 12 to 01. Each needs thousands of ticks with the seconds and minutes both at 59 at the right moment. The stimulus first applies ticks in an irregular on/off pattern, which exercises holding and the lower carries. It then applies a tick on every cycle until a full 43,200-tick day has passed. That run reaches every hour transition, including the wrap to 01 and the return to 12:00:00. A behavioural model of the time in seconds is compared against the outputs on every cycle.

// File: rtl/hms_pkg.sv
package hms_pkg;
    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic   tens;
        digit_t ones;
    } hour_t;
endpackage

// File: rtl/hms_decade.sv
module hms_decade #(
    parameter int W    = 4,
    parameter int LAST = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    output logic [W-1:0] digit_o,
    output logic         last_o
);
    localparam logic [W-1:0] LAST_V = W'(LAST);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en_i) begin
            if (cnt_q == LAST_V) cnt_d = '0;
            else                 cnt_d = cnt_q + ONE_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign digit_o = cnt_q;
    assign last_o  = (cnt_q == LAST_V);
endmodule

// File: rtl/hms_mod60.sv
module hms_mod60
    import hms_pkg::*;
#(
    parameter int ONES_LAST = 9,
    parameter int TENS_LAST = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en_i,
    output digit_t ones_o,
    output digit_t tens_o,
    output logic   last_o
);
    localparam int STAGES = 2;

    function automatic int stage_last(input int idx);
        return (idx == 0) ? ONES_LAST : TENS_LAST;
    endfunction

    logic [STAGES-1:0]              en_chain;
    logic [STAGES-1:0]              at_last;
    logic [STAGES-1:0][DIGIT_W-1:0] digits;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign en_chain[i] = en_i;
        end else begin : g_next
            assign en_chain[i] = en_chain[i-1] & at_last[i-1];
        end

        hms_decade #(
            .W    (DIGIT_W),
            .LAST (stage_last(i))
        ) u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_chain[i]),
            .digit_o (digits[i]),
            .last_o  (at_last[i])
        );
    end

    assign ones_o = digits[0];
    assign tens_o = digits[1];
    assign last_o = &at_last;
endmodule

// File: rtl/hms_hours12.sv
module hms_hours12
    import hms_pkg::*;
#(
    parameter int RESET_ONES = 2,
    parameter int WRAP_ONES  = 2,
    parameter int FIRST_ONES = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en_i,
    output logic   tens_o,
    output digit_t ones_o
);
    localparam digit_t RESET_V = DIGIT_W'(RESET_ONES);
    localparam digit_t WRAP_V  = DIGIT_W'(WRAP_ONES);
    localparam digit_t FIRST_V = DIGIT_W'(FIRST_ONES);
    localparam digit_t NINE_V  = DIGIT_W'(9);
    localparam digit_t ONE_V   = DIGIT_W'(1);

    hour_t hr_d, hr_q;

    always_comb begin
        hr_d = hr_q;
        if (en_i) begin
            if (hr_q.tens && hr_q.ones == WRAP_V) begin
                hr_d.tens = 1'b0;
                hr_d.ones = FIRST_V;
            end else if (hr_q.ones == NINE_V) begin
                hr_d.tens = 1'b1;
                hr_d.ones = '0;
            end else begin
                hr_d.ones = hr_q.ones + ONE_V;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q.tens <= 1'b1;
            hr_q.ones <= RESET_V;
        end else begin
            hr_q <= hr_d;
        end
    end

    assign tens_o = hr_q.tens;
    assign ones_o = hr_q.ones;
endmodule

// File: rtl/hms_timekeeper.sv
module hms_timekeeper
    import hms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic       hr_tens
);
    logic sec_at59, min_at59;
    logic min_en, hr_en;

    assign min_en = tick & sec_at59;
    assign hr_en  = min_en & min_at59;

    hms_mod60 u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick),
        .ones_o (sec_ones),
        .tens_o (sec_tens),
        .last_o (sec_at59)
    );

    hms_mod60 u_min (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (min_en),
        .ones_o (min_ones),
        .tens_o (min_tens),
        .last_o (min_at59)
    );

    hms_hours12 u_hr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (hr_en),
        .tens_o (hr_tens),
        .ones_o (hr_ones)
    );
endmodule

// File: rtl/hms_timekeeper_chk.sv
module hms_timekeeper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic [3:0] hr_ones,
    input logic       hr_tens
);
    logic sec59, min59;
    assign sec59 = (sec_tens == 4'd5) && (sec_ones == 4'd9);
    assign min59 = (min_tens == 4'd5) && (min_ones == 4'd9);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens}));

    a_r3_units_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec_ones != 4'd9) |=> (sec_ones == $past(sec_ones) + 4'd1));

    a_r4_seconds_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec59) |=> (sec_ones == 4'd0 && sec_tens == 4'd0));

    a_r5_minutes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sec59) |=> $stable({min_ones, min_tens}));

    a_r6_nine_to_ten: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec59 && min59 && !hr_tens && hr_ones == 4'd9) |=> (hr_tens && hr_ones == 4'd0));

    a_r7_twelve_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sec59 && min59 && hr_tens && hr_ones == 4'd2) |=> (!hr_tens && hr_ones == 4'd1));

    a_r8_legal_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_ones <= 4'd9 && sec_tens <= 4'd5 && min_ones <= 4'd9 && min_tens <= 4'd5
         && (hr_tens ? hr_ones <= 4'd2 : (hr_ones != 4'd0 && hr_ones <= 4'd9))));
endmodule

bind hms_timekeeper hms_timekeeper_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sec_ones (sec_ones),
    .sec_tens (sec_tens),
    .min_ones (min_ones),
    .min_tens (min_tens),
    .hr_ones  (hr_ones),
    .hr_tens  (hr_tens)
);

// File: tb/hms_timekeeper_tb.sv
module hms_timekeeper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DAY_TICKS  = 43200;
    localparam int GAPPY_CYC  = 5000;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones;
    logic       hr_tens;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hms_timekeeper u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .sec_ones(sec_ones), .sec_tens(sec_tens),
        .min_ones(min_ones), .min_tens(min_tens),
        .hr_ones(hr_ones), .hr_tens(hr_tens)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int obs_sec();
        return int'(sec_tens) * 10 + int'(sec_ones);
    endfunction
    function automatic int obs_min();
        return int'(min_tens) * 10 + int'(min_ones);
    endfunction
    function automatic int obs_hr();
        return (hr_tens ? 10 : 0) + int'(hr_ones);
    endfunction

    int  m_h = 12, m_m = 0, m_s = 0;
    int  applied = 0;
    int  last_change = 0;
    int  prev_snap = 0;
    int  prev_h = 12;
    int  lcg = 12345;
    bit  prev_tick = 1'b0;
    bit  full_pending = 1'b0;
    bit  saw_nine_ten = 1'b0;
    bit  saw_twelve_one = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check(obs_hr() == 12 && obs_min() == 0 && obs_sec() == 0, "R1 in reset",
              obs_hr() * 10000 + obs_min() * 100 + obs_sec(), 120000);
        rst_n = 1'b1;
        while (applied < DAY_TICKS + 200 && cyc < WATCHDOG) begin
            @(negedge clk);
            // reference comparisons every cycle
            check(obs_sec() == m_s && sec_ones <= 4'd9 && sec_tens <= 4'd5, "R3 seconds", obs_sec(), m_s);
            check(obs_min() == m_m, "R5 minutes", obs_min(), m_m);
            check(obs_hr() == m_h && hr_ones <= 4'd9, "R7 hours", obs_hr(), m_h);
            check(obs_hr() >= 1 && obs_hr() <= 12, "R8 hour range", obs_hr(), 1);
            if (applied == 0)
                check(obs_hr() * 10000 + obs_min() * 100 + obs_sec() == 120000, "R1 after release",
                      obs_hr() * 10000 + obs_min() * 100 + obs_sec(), 120000);
            if (!prev_tick && applied > 0)
                check(obs_hr() * 10000 + obs_min() * 100 + obs_sec() == prev_snap, "R2 hold",
                      obs_hr() * 10000 + obs_min() * 100 + obs_sec(), prev_snap);
            if (obs_hr() != prev_h) begin
                check(applied - last_change == 3600, "R9 hour period", applied - last_change, 3600);
                if (prev_h == 9) begin
                    saw_nine_ten = 1'b1;
                    check(hr_tens == 1'b1 && hr_ones == 4'd0, "R6 nine to ten", obs_hr(), 10);
                end
                if (prev_h == 12) begin
                    saw_twelve_one = 1'b1;
                    check(hr_tens == 1'b0 && hr_ones == 4'd1, "R7 twelve to one", obs_hr(), 1);
                end
                if (m_s == 0 && m_m == 0)
                    check(obs_min() == 0 && obs_sec() == 0, "R4 carry clears", obs_min() * 100 + obs_sec(), 0);
                last_change = applied;
            end
            if (full_pending) begin
                full_pending = 1'b0;
                check(obs_hr() * 10000 + obs_min() * 100 + obs_sec() == 120000, "R9 full day",
                      obs_hr() * 10000 + obs_min() * 100 + obs_sec(), 120000);
            end
            prev_h    = obs_hr();
            prev_snap = obs_hr() * 10000 + obs_min() * 100 + obs_sec();

            // choose next tick
            if (cyc < GAPPY_CYC) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
                prev_tick = ((lcg >> 16) % 3) != 0;
            end else begin
                prev_tick = 1'b1;
            end
            tick = prev_tick;
            if (prev_tick) begin
                applied++;
                m_s++;
                if (m_s == 60) begin
                    m_s = 0;
                    m_m++;
                    if (m_m == 60) begin
                        m_m = 0;
                        m_h = (m_h == 12) ? 1 : m_h + 1;
                    end
                end
                if (applied == DAY_TICKS) full_pending = 1'b1;
            end
        end
        tick = 1'b0;
        check(cyc < WATCHDOG, "watchdog", cyc, WATCHDOG);
        check(saw_nine_ten, "R6 reached", int'(saw_nine_ten), 1);
        check(saw_twelve_one, "R7 reached", int'(saw_twelve_one), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule